// File: doc/BRIEF.md
# Indirect Register Bridge

This block gives a 32-bit host register port access to a private bank of 256 internal 8-bit registers through a single control word. Each host write carries three fields: a read-select flag, an internal address and a data byte. When the flag is clear, the byte is stored in the internal register named by the address. When the flag is set, the address is remembered as the read pointer and the byte is dropped.

A host read of the control word returns the internal register that the read pointer names, together with the pointer itself. Software therefore reads an internal register in two steps. It first writes the address with the flag set, then it issues a read. The internal bank stands in for the circuits that would sit behind it and is a plain register array.

The asynchronous active-low reset is released synchronously inside the block. Read data arrives one cycle after the read strobe and stays on the port until the next read.

Top module: `idx_bridge`

## Requirements
- R1: After reset, every internal register and the read pointer are zero, `host_rd_valid` is low and `host_rd_data` is zero. A first read therefore returns the register at address zero, whose value is 0.
- R2: A host write with bit 16 clear stores bits 7:0 into the internal register addressed by bits 15:8. The new value is seen by a read strobed in the cycle after the write.
- R3: A host write with bit 16 set loads bits 15:8 into the read pointer by the next cycle. It changes no internal register, whatever bits 7:0 hold.
- R4: A read strobe in cycle t raises `host_rd_valid` for exactly cycle t+1. In that cycle `host_rd_data` is {16'b0, pointer, bank[pointer]}, with the pointer in bits 15:8 and the register byte in bits 7:0.
- R5: Bits 31:16 of the read data are always zero. Bits 31:17 of a host write have no effect.
- R6: A write with bit 16 clear leaves the read pointer unchanged.
- R7: When a read strobe and a write fall in the same cycle, the read returns the pointer and register contents as they stood before that write.
- R8: Between reads, `host_rd_data` holds the value of the last read and `host_rd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wr_data | input | 32 | Control word: bit 16 read-select flag, 15:8 address, 7:0 data |
| host_rd_en | input | 1 | Host read strobe for the control word |
| host_rd_data | output | 32 | Read result: 15:8 read pointer, 7:0 register byte |
| host_rd_valid | output | 1 | High for one cycle when read data is new |

## Verification
The hardest case to reach from the ports is a read strobed in the same cycle as a write that changes its result. That write may replace the byte at the current pointer, or it may move the pointer. Only the ordering rule of R7 decides which value comes back. The stimulus sets up a known byte behind the pointer and then issues a read and a conflicting write together. A second read follows to show that the write still took effect. A separate sequence sends set-flag writes that carry non-zero data bytes. It then reads back the addresses those writes named, to confirm that the dropped bytes never reached the bank.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_STORE = 2'd1,
    CMD_POINT = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/idx_rst_sync.sv
module idx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/idx_cmd_decode.sv
module idx_cmd_decode
  import idx_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic [HOST_W-1:0] wr_word,
  output cmd_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int FLAG_POS = ADDR_W + DATA_W;

  always_comb begin
    addr = wr_word[FLAG_POS-1:DATA_W];
    data = wr_word[DATA_W-1:0];
    if (!wr_en)                 kind = CMD_IDLE;
    else if (wr_word[FLAG_POS]) kind = CMD_POINT;
    else                        kind = CMD_STORE;
  end
endmodule

// File: rtl/idx_pointer.sv
module idx_pointer
  import idx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] ptr_q
);
  logic              ptr_en;
  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_en = (kind == CMD_POINT);
    ptr_d  = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/idx_reg_bank.sv
module idx_reg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0]  ent_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_comb begin
      ent_en[i] = we && (waddr == ADDR_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q[i] <= '0;
      else if (ent_en[i]) ent_q[i] <= wdata;
    end
  end

  assign rdata = ent_q[raddr];
endmodule

// File: rtl/idx_rd_resp.sv
module idx_rd_resp #(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] byte_in,
  output logic [HOST_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PAD_W = HOST_W - ADDR_W - DATA_W;

  logic [HOST_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    data_en = rd_en;
    data_d  = {{PAD_W{1'b0}}, ptr, byte_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (data_en) rd_data <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end
endmodule

// File: rtl/idx_bridge.sv
module idx_bridge
  import idx_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [HOST_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [HOST_W-1:0] host_rd_data,
  output logic              host_rd_valid
);
  logic              rst_sync_n;
  cmd_kind_e         kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] bank_byte;
  logic              bank_we;

  idx_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  idx_cmd_decode #(.HOST_W(HOST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .wr_en(host_wr_en), .wr_word(host_wr_data),
    .kind(kind), .addr(cmd_addr), .data(cmd_data)
  );

  idx_pointer #(.ADDR_W(ADDR_W)) ptr_i (
    .clk(clk), .rst_n(rst_sync_n), .kind(kind), .addr(cmd_addr), .ptr_q(ptr_q)
  );

  assign bank_we = (kind == CMD_STORE);

  idx_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst_n(rst_sync_n), .we(bank_we), .waddr(cmd_addr),
    .wdata(cmd_data), .raddr(ptr_q), .rdata(bank_byte)
  );

  idx_rd_resp #(.HOST_W(HOST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) resp_i (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(host_rd_en), .ptr(ptr_q),
    .byte_in(bank_byte), .rd_data(host_rd_data), .rd_valid(host_rd_valid)
  );
endmodule

// File: rtl/idx_bridge_chk.sv
module idx_bridge_chk #(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [HOST_W-1:0] host_wr_data,
  input logic              host_rd_en,
  input logic [HOST_W-1:0] host_rd_data,
  input logic              host_rd_valid,
  input logic [ADDR_W-1:0] ptr_q
);
  localparam int FLAG_POS = ADDR_W + DATA_W;

  p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rd_valid);

  p_valid_only_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_en |=> !host_rd_valid);

  p_data_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_en |=> $stable(host_rd_data));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_valid |-> (host_rd_data[HOST_W-1:FLAG_POS] == '0));

  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_data[FLAG_POS]) |=> (ptr_q == $past(host_wr_data[FLAG_POS-1:DATA_W])));

  p_ptr_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_en && host_wr_data[FLAG_POS]) |=> $stable(ptr_q));

  p_ptr_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> (host_rd_data[FLAG_POS-1:DATA_W] == $past(ptr_q)));
endmodule

bind idx_bridge idx_bridge_chk #(.HOST_W(HOST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
  .host_rd_en(host_rd_en), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
  .ptr_q(ptr_q)
);

// File: tb/idx_bridge_tb_top.sv
module idx_bridge_tb_top;
  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [31:0] host_wr_data;
  logic        host_rd_en;
  logic [31:0] host_rd_data;
  logic        host_rd_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0]  m_bank [256];
  logic [7:0]  m_ptr;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] last_rd;

  idx_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One host cycle: optional write and optional read in the same cycle.
  task automatic op(bit wr, logic [31:0] wd, bit rd, string req);
    @(negedge clk);
    host_wr_en   = wr;
    host_wr_data = wd;
    host_rd_en   = rd;
    if (rd) begin
      exp_q.push_back({16'h0, m_ptr, m_bank[m_ptr]});
      tag_q.push_back(req);
    end
    if (wr) begin
      if (wd[16]) m_ptr = wd[15:8];
      else        m_bank[wd[15:8]] = wd[7:0];
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 32'h0, 0, "");
  endtask

  task automatic store(logic [7:0] a, logic [7:0] d, logic [14:0] junk = '0);
    op(1, {junk, 1'b0, a, d}, 0, "R2");
  endtask

  task automatic point(logic [7:0] a, logic [7:0] d = 8'h0);
    op(1, {15'h0, 1'b1, a, d}, 0, "R3");
  endtask

  // Monitor: compares each returned read with the scoreboard queue.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (host_rd_valid) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R4 actual=valid expected=no read pending");
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, host_rd_data, e);
          check("R5", {16'h0, host_rd_data[31:16]}, 32'h0);
        end
        last_rd = host_rd_data;
      end else begin
        check("R8", host_rd_data, last_rd);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    host_wr_en = 0; host_wr_data = 0; host_rd_en = 0;
    m_ptr = 0; last_rd = 0;
    for (int i = 0; i < 256; i++) m_bank[i] = 8'h0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", {31'h0, host_rd_valid}, 32'h0);
    check("R1", host_rd_data, 32'h0);
    op(0, 0, 1, "R1");
    idle(2);

    // R2: store then read back, including both ends of the address range
    store(8'h00, 8'hA5); point(8'h00); op(0, 0, 1, "R2");
    store(8'hFF, 8'h3C); point(8'hFF); op(0, 0, 1, "R2");
    for (int i = 0; i < 16; i++) store(8'(i * 17 + 3), 8'(8'hC0 ^ i));
    for (int i = 0; i < 16; i++) begin
      point(8'(i * 17 + 3));
      op(0, 0, 1, "R2");
    end
    // R2: read strobed in the cycle right after a store
    point(8'h10); store(8'h10, 8'h5A); op(0, 0, 1, "R2");
    idle(2);

    // R3: set-flag writes drop their data byte
    store(8'h20, 8'h11);
    point(8'h20, 8'hEE); op(0, 0, 1, "R3");
    point(8'h30, 8'h77); op(0, 0, 1, "R3");

    // R5: upper write bits ignored
    store(8'h31, 8'h99, 15'h7FFF); point(8'h31); op(0, 0, 1, "R5");

    // R6: stores elsewhere keep the pointer
    point(8'h40); store(8'h41, 8'h66); store(8'h40, 8'h42); op(0, 0, 1, "R6");

    // R7: read and conflicting write in the same cycle
    point(8'h50); store(8'h50, 8'h12);
    op(1, {15'h0, 1'b0, 8'h50, 8'h34}, 1, "R7");
    op(0, 0, 1, "R7");
    op(1, {15'h0, 1'b1, 8'h60, 8'h00}, 1, "R7");
    op(0, 0, 1, "R7");

    // R4/R8: back-to-back reads, then a long idle gap
    op(0, 0, 1, "R4"); op(0, 0, 1, "R4");
    idle(6);

    idle(3);
    check("R4", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule